// File: doc/BRIEF.md
# Double-Buffered Polyphase Coefficient Store

This block holds the coefficient tables of a polyphase video scaler. The scaler filters with up to eight taps and sixty-four phases. Because the phase responses are symmetric, only phases 0 to 32 are stored; a read for a higher phase is served from the mirror phase with the tap order reversed. Six filter kinds are kept: vertical and horizontal tables for each of luma, chroma and alpha.

A host loads one filter at a time. It first issues a select write that names the filter kind and its tap count. This also rewinds the phase and pair counters. It then issues data writes, each carrying an even-tap and an odd-tap coefficient with separate enables. A write cursor steps through the tap pairs of a phase and then on to the next phase. Two complete banks exist. Loads always land in the bank that is not live. The datapath reads the live bank. The host's bank choice takes effect only on a frame-start strobe, so a table never changes in the middle of a frame.

The read port returns a coefficient one cycle after the filter kind, phase and tap are presented. When the separate-chroma control is low, chroma reads are answered from the luma tables.

Top module: `pcoef_ram`

## Requirements
- R1: After reset, live_bank is 0 and rd_coef is 0.
- R2: A select write sets the filter kind and tap count and rewinds the cursor to phase 0, pair 0. Each later data write stores at the cursor. The pair then advances, and after pair (taps+1)/2-1 it wraps to 0 while the phase advances. Pair p holds taps 2p (even half) and 2p+1 (odd half).
- R3: The even and odd halves of a data write are stored only when their own enable is high. A disabled half leaves the stored value unchanged.
- R4: When tap 2p+1 is not below the tap count (odd tap count, last pair), the odd half is stored as zero whatever value is written.
- R5: Bits 1:0 of every stored coefficient are zero, whatever the written value.
- R6: Once phase 32 is complete, further data writes are ignored until the next select write.
- R7: Select and data writes go to the bank that is not live. live_bank takes the value of bank_sel only in the cycle after frame_start is high; otherwise it holds.
- R8: A read of phase p > 32 returns the coefficient stored at phase 64-p and tap (taps-1-t), using the tap count of that kind in the live bank.
- R9: A read of phase p > 32 with tap t not below the tap count returns 0.
- R10: Filter kind encoding: 0 luma vertical, 1 luma horizontal, 2 chroma vertical, 3 chroma horizontal, 4 alpha vertical, 5 alpha horizontal. When chroma_sep is 0, a read of kind 2 or 3 returns the kind 0 or kind 1 table. When chroma_sep is 1, it returns the chroma table.
- R11: rd_coef reflects the read inputs sampled at a rising clock edge and holds its value until the next edge.
- R12: Kinds 6 and 7 are invalid. Data writes to them store nothing, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_wr | input | 1 | Select write strobe |
| sel_kind | input | 3 | Filter kind for the select write |
| sel_taps | input | 4 | Tap count (1 to 8) for the select write |
| dat_wr | input | 1 | Data write strobe |
| dat_even | input | 14 | Even-tap coefficient |
| dat_even_en | input | 1 | Store enable for the even half |
| dat_odd | input | 14 | Odd-tap coefficient |
| dat_odd_en | input | 1 | Store enable for the odd half |
| bank_sel | input | 1 | Bank requested as live |
| frame_start | input | 1 | Frame-start strobe that commits bank_sel |
| chroma_sep | input | 1 | 1: chroma reads use chroma tables; 0: luma tables |
| live_bank | output | 1 | Bank currently read by the datapath |
| rd_kind | input | 3 | Read filter kind |
| rd_phase | input | 6 | Read phase, 0 to 63 |
| rd_tap | input | 3 | Read tap index |
| rd_coef | output | 14 | Coefficient, registered |

## Verification
The assertions rely on the host never asserting sel_wr and dat_wr in the same cycle, and on a programmed tap count between 1 and 8. The mirror mapping and the pair arithmetic are defined only over that range. The stimulus holds to both. Every write goes through one task, and each task drives a single strobe for a single cycle. Tap counts of 4, 5 and 8 are used. The kind-6 select carries a legal count, so the only illegal condition the block sees is the kind itself.

// File: rtl/pcoef_pkg.sv
package pcoef_pkg;
    localparam int KIND_W    = 3;
    localparam int NUM_KINDS = 6;

    typedef enum logic [KIND_W-1:0] {
        FK_LUMA_V  = 3'd0,
        FK_LUMA_H  = 3'd1,
        FK_CHR_V   = 3'd2,
        FK_CHR_H   = 3'd3,
        FK_ALPHA_V = 3'd4,
        FK_ALPHA_H = 3'd5
    } filt_kind_e;
endpackage

// File: rtl/pcoef_wr_seq.sv
module pcoef_wr_seq
    import pcoef_pkg::*;
#(
    parameter int MAX_TAPS  = 8,
    parameter int STORED_PH = 33,
    localparam int CNT_W  = $clog2(MAX_TAPS + 1),
    localparam int PAIRS  = (MAX_TAPS + 1) / 2,
    localparam int PAIR_W = (PAIRS > 1) ? $clog2(PAIRS) : 1,
    localparam int PH_W   = $clog2(STORED_PH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr,
    input  logic [KIND_W-1:0] sel_kind,
    input  logic [CNT_W-1:0]  sel_taps,
    input  logic              dat_wr,
    input  logic              bank_sel,
    input  logic              frame_start,
    output logic              wr_en,
    output logic [KIND_W-1:0] wr_kind,
    output logic [PH_W-1:0]   wr_phase,
    output logic [PAIR_W-1:0] wr_pair,
    output logic              wr_odd_zero,
    output logic              taps_we,
    output logic              live_bank
);
    typedef struct packed {
        logic [KIND_W-1:0] kind;
        logic [CNT_W-1:0]  taps;
        logic [PAIR_W-1:0] pair;
        logic [PH_W-1:0]   phase;
        logic              live;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    in_range;
    logic    last_pair;

    always_comb begin
        st_d      = st_q;
        in_range  = st_q.phase < PH_W'(STORED_PH);
        last_pair = (int'(st_q.pair) + 1) >= ((int'(st_q.taps) + 1) / 2);
        if (sel_wr) begin
            st_d.kind  = sel_kind;
            st_d.taps  = sel_taps;
            st_d.pair  = '0;
            st_d.phase = '0;
        end else if (dat_wr && in_range) begin
            if (last_pair) begin
                st_d.pair  = '0;
                st_d.phase = st_q.phase + 1'b1;
            end else begin
                st_d.pair = st_q.pair + 1'b1;
            end
        end
        if (frame_start) begin
            st_d.live = bank_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en       = dat_wr && !sel_wr && in_range && (int'(st_q.kind) < NUM_KINDS);
    assign wr_kind     = st_q.kind;
    assign wr_phase    = st_q.phase;
    assign wr_pair     = st_q.pair;
    assign wr_odd_zero = (2 * int'(st_q.pair) + 1) >= int'(st_q.taps);
    assign taps_we     = sel_wr && (int'(sel_kind) < NUM_KINDS);
    assign live_bank   = st_q.live;

    // R2
    idx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> (st_q.pair == '0) && (st_q.phase == '0));

    // R6
    phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase <= PH_W'(STORED_PH));

    // R7
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(st_q.live));
endmodule

// File: rtl/pcoef_rd_map.sv
module pcoef_rd_map
    import pcoef_pkg::*;
#(
    parameter int NUM_PHASES = 64,
    parameter int MAX_TAPS   = 8,
    localparam int PHASE_W = $clog2(NUM_PHASES),
    localparam int TAP_W   = (MAX_TAPS > 1) ? $clog2(MAX_TAPS) : 1,
    localparam int CNT_W   = $clog2(MAX_TAPS + 1)
) (
    input  logic [KIND_W-1:0]  rd_kind,
    input  logic [PHASE_W-1:0] rd_phase,
    input  logic [TAP_W-1:0]   rd_tap,
    input  logic               chroma_sep,
    input  logic [CNT_W-1:0]   lk_taps,
    output logic [KIND_W-1:0]  eff_kind,
    output logic [PHASE_W-1:0] s_phase,
    output logic [TAP_W-1:0]   s_tap,
    output logic               rd_zero
);
    logic mirror;

    always_comb begin
        eff_kind = rd_kind;
        if (!chroma_sep && (rd_kind == FK_CHR_V || rd_kind == FK_CHR_H)) begin
            eff_kind = rd_kind - KIND_W'(2);
        end
    end

    always_comb begin
        mirror  = int'(rd_phase) > (NUM_PHASES / 2);
        s_phase = rd_phase;
        s_tap   = rd_tap;
        if (mirror) begin
            s_phase = PHASE_W'(NUM_PHASES - int'(rd_phase));
            s_tap   = TAP_W'(int'(lk_taps) - 1 - int'(rd_tap));
        end
        rd_zero = (int'(eff_kind) >= NUM_KINDS) ||
                  (mirror && (int'(rd_tap) >= int'(lk_taps)));
    end
endmodule

// File: rtl/pcoef_store.sv
module pcoef_store
    import pcoef_pkg::*;
#(
    parameter int COEF_W     = 14,
    parameter int NUM_PHASES = 64,
    parameter int MAX_TAPS   = 8,
    localparam int STORED_PH = NUM_PHASES / 2 + 1,
    localparam int PHASE_W   = $clog2(NUM_PHASES),
    localparam int TAP_W     = (MAX_TAPS > 1) ? $clog2(MAX_TAPS) : 1,
    localparam int CNT_W     = $clog2(MAX_TAPS + 1),
    localparam int PAIRS     = (MAX_TAPS + 1) / 2,
    localparam int PAIR_W    = (PAIRS > 1) ? $clog2(PAIRS) : 1,
    localparam int PH_W      = $clog2(STORED_PH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_bank,
    input  logic [KIND_W-1:0]  wr_kind,
    input  logic [PH_W-1:0]    wr_phase,
    input  logic [PAIR_W-1:0]  wr_pair,
    input  logic [COEF_W-1:0]  wr_even,
    input  logic               wr_even_en,
    input  logic [COEF_W-1:0]  wr_odd,
    input  logic               wr_odd_en,
    input  logic               wr_odd_zero,
    input  logic               taps_we,
    input  logic [KIND_W-1:0]  taps_kind,
    input  logic [CNT_W-1:0]   taps_val,
    input  logic               live_bank,
    input  logic [KIND_W-1:0]  lk_kind,
    output logic [CNT_W-1:0]   lk_taps,
    input  logic [PHASE_W-1:0] rd_phase,
    input  logic [TAP_W-1:0]   rd_tap,
    input  logic               rd_zero,
    output logic [COEF_W-1:0]  rd_coef
);
    localparam logic [COEF_W-1:0] LSB_CLR = ~COEF_W'(3);

    logic [COEF_W-1:0] mem_q  [2][NUM_KINDS][STORED_PH][MAX_TAPS];
    logic [CNT_W-1:0]  taps_q [2][NUM_KINDS];
    logic [COEF_W-1:0] rd_coef_d, rd_coef_q;
    logic [TAP_W-1:0]  even_idx, odd_idx;
    logic              odd_fits;
    logic [KIND_W-1:0] lk_safe;

    assign even_idx = TAP_W'(2 * int'(wr_pair));
    assign odd_idx  = TAP_W'(2 * int'(wr_pair) + 1);
    assign odd_fits = (2 * int'(wr_pair) + 1) < MAX_TAPS;
    assign lk_safe  = (int'(lk_kind) < NUM_KINDS) ? lk_kind : '0;
    assign lk_taps  = taps_q[live_bank][lk_safe];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++) begin
                for (int k = 0; k < NUM_KINDS; k++) begin
                    taps_q[b][k] <= '0;
                    for (int p = 0; p < STORED_PH; p++) begin
                        for (int t = 0; t < MAX_TAPS; t++) begin
                            mem_q[b][k][p][t] <= '0;
                        end
                    end
                end
            end
        end else begin
            if (taps_we) begin
                taps_q[wr_bank][taps_kind] <= taps_val;
            end
            if (wr_en && wr_even_en) begin
                mem_q[wr_bank][wr_kind][wr_phase][even_idx] <= wr_even & LSB_CLR;
            end
            if (wr_en && wr_odd_en && odd_fits) begin
                mem_q[wr_bank][wr_kind][wr_phase][odd_idx] <=
                    wr_odd_zero ? '0 : (wr_odd & LSB_CLR);
            end
        end
    end

    always_comb begin
        rd_coef_d = rd_zero ? '0 : mem_q[live_bank][lk_safe][rd_phase][rd_tap];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_coef_q <= '0;
        end else begin
            rd_coef_q <= rd_coef_d;
        end
    end

    assign rd_coef = rd_coef_q;

    // R5
    lsb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_coef_q[1:0] == 2'b00);
endmodule

// File: rtl/pcoef_ram.sv
module pcoef_ram
    import pcoef_pkg::*;
#(
    parameter int COEF_W     = 14,
    parameter int NUM_PHASES = 64,
    parameter int MAX_TAPS   = 8,
    localparam int STORED_PH = NUM_PHASES / 2 + 1,
    localparam int PHASE_W   = $clog2(NUM_PHASES),
    localparam int TAP_W     = (MAX_TAPS > 1) ? $clog2(MAX_TAPS) : 1,
    localparam int CNT_W     = $clog2(MAX_TAPS + 1),
    localparam int PAIRS     = (MAX_TAPS + 1) / 2,
    localparam int PAIR_W    = (PAIRS > 1) ? $clog2(PAIRS) : 1,
    localparam int PH_W      = $clog2(STORED_PH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_wr,
    input  logic [KIND_W-1:0]  sel_kind,
    input  logic [CNT_W-1:0]   sel_taps,
    input  logic               dat_wr,
    input  logic [COEF_W-1:0]  dat_even,
    input  logic               dat_even_en,
    input  logic [COEF_W-1:0]  dat_odd,
    input  logic               dat_odd_en,
    input  logic               bank_sel,
    input  logic               frame_start,
    input  logic               chroma_sep,
    output logic               live_bank,
    input  logic [KIND_W-1:0]  rd_kind,
    input  logic [PHASE_W-1:0] rd_phase,
    input  logic [TAP_W-1:0]   rd_tap,
    output logic [COEF_W-1:0]  rd_coef
);
    logic              wr_en, wr_odd_zero, taps_we;
    logic [KIND_W-1:0] wr_kind, eff_kind;
    logic [PH_W-1:0]   wr_phase;
    logic [PAIR_W-1:0] wr_pair;
    logic [CNT_W-1:0]  lk_taps;
    logic [PHASE_W-1:0] s_phase;
    logic [TAP_W-1:0]  s_tap;
    logic              rd_zero;

    pcoef_wr_seq #(
        .MAX_TAPS  (MAX_TAPS),
        .STORED_PH (STORED_PH)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_wr      (sel_wr),
        .sel_kind    (sel_kind),
        .sel_taps    (sel_taps),
        .dat_wr      (dat_wr),
        .bank_sel    (bank_sel),
        .frame_start (frame_start),
        .wr_en       (wr_en),
        .wr_kind     (wr_kind),
        .wr_phase    (wr_phase),
        .wr_pair     (wr_pair),
        .wr_odd_zero (wr_odd_zero),
        .taps_we     (taps_we),
        .live_bank   (live_bank)
    );

    pcoef_rd_map #(
        .NUM_PHASES (NUM_PHASES),
        .MAX_TAPS   (MAX_TAPS)
    ) map_i (
        .rd_kind    (rd_kind),
        .rd_phase   (rd_phase),
        .rd_tap     (rd_tap),
        .chroma_sep (chroma_sep),
        .lk_taps    (lk_taps),
        .eff_kind   (eff_kind),
        .s_phase    (s_phase),
        .s_tap      (s_tap),
        .rd_zero    (rd_zero)
    );

    pcoef_store #(
        .COEF_W     (COEF_W),
        .NUM_PHASES (NUM_PHASES),
        .MAX_TAPS   (MAX_TAPS)
    ) store_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_bank     (~live_bank),
        .wr_kind     (wr_kind),
        .wr_phase    (wr_phase),
        .wr_pair     (wr_pair),
        .wr_even     (dat_even),
        .wr_even_en  (dat_even_en),
        .wr_odd      (dat_odd),
        .wr_odd_en   (dat_odd_en),
        .wr_odd_zero (wr_odd_zero),
        .taps_we     (taps_we),
        .taps_kind   (sel_kind),
        .taps_val    (sel_taps),
        .live_bank   (live_bank),
        .lk_kind     (eff_kind),
        .lk_taps     (lk_taps),
        .rd_phase    (s_phase),
        .rd_tap      (s_tap),
        .rd_zero     (rd_zero),
        .rd_coef     (rd_coef)
    );

    // R12
    bad_kind_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_kind) >= NUM_KINDS) |=> (rd_coef == '0));
endmodule

// File: tb/pcoef_ram_tb.sv
module pcoef_ram_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_wr = 1'b0;
    logic [2:0]  sel_kind = '0;
    logic [3:0]  sel_taps = '0;
    logic        dat_wr = 1'b0;
    logic [13:0] dat_even = '0;
    logic        dat_even_en = 1'b0;
    logic [13:0] dat_odd = '0;
    logic        dat_odd_en = 1'b0;
    logic        bank_sel = 1'b0;
    logic        frame_start = 1'b0;
    logic        chroma_sep = 1'b1;
    logic        live_bank;
    logic [2:0]  rd_kind = '0;
    logic [5:0]  rd_phase = '0;
    logic [2:0]  rd_tap = '0;
    logic [13:0] rd_coef;

    int tests = 0;
    int fails = 0;

    logic [13:0] mdl [0:1][0:7][0:32][0:7];
    int          mtaps [0:1][0:7];
    int          mcur = 0;
    int          m_kind = 0, m_taps = 0, m_pair = 0, m_phase = 0;

    always #4 clk = ~clk;

    pcoef_ram dut_i (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_kind(sel_kind),
        .sel_taps(sel_taps), .dat_wr(dat_wr), .dat_even(dat_even),
        .dat_even_en(dat_even_en), .dat_odd(dat_odd), .dat_odd_en(dat_odd_en),
        .bank_sel(bank_sel), .frame_start(frame_start), .chroma_sep(chroma_sep),
        .live_bank(live_bank), .rd_kind(rd_kind), .rd_phase(rd_phase),
        .rd_tap(rd_tap), .rd_coef(rd_coef)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic [13:0] act, input logic [13:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [13:0] pat(int seed, int ph, int tap);
        return 14'((seed << 10) ^ (ph << 4) ^ (tap << 1) ^ 3);
    endfunction

    function automatic logic [13:0] exp_rd(int kind, int ph, int tap);
        int k = kind;
        int n;
        if (!chroma_sep && (k == 2 || k == 3)) k = k - 2;
        if (k >= 6) return '0;
        n = mtaps[mcur][k];
        if (ph <= 32) return mdl[mcur][k][ph][tap];
        if (tap >= n) return '0;
        return mdl[mcur][k][64 - ph][n - 1 - tap];
    endfunction

    task automatic do_sel(int kind, int taps);
        sel_wr = 1'b1; sel_kind = 3'(kind); sel_taps = 4'(taps);
        tick();
        sel_wr = 1'b0;
        m_kind = kind; m_taps = taps; m_pair = 0; m_phase = 0;
        if (kind < 6) mtaps[1 - mcur][kind] = taps;
    endtask

    task automatic do_dat(int e, bit een, int o, bit oen);
        int wb = 1 - mcur;
        int np = (m_taps + 1) / 2;
        dat_wr = 1'b1; dat_even = e[13:0]; dat_even_en = een;
        dat_odd = o[13:0]; dat_odd_en = oen;
        tick();
        dat_wr = 1'b0; dat_even_en = 1'b0; dat_odd_en = 1'b0;
        if (m_kind < 6 && m_phase <= 32) begin
            if (een) mdl[wb][m_kind][m_phase][2*m_pair] = e[13:0] & 14'h3ffc;
            if (oen && 2*m_pair + 1 < 8)
                mdl[wb][m_kind][m_phase][2*m_pair+1] =
                    (2*m_pair + 1 >= m_taps) ? 14'h0 : (o[13:0] & 14'h3ffc);
        end
        if (m_phase <= 32) begin
            if (m_pair + 1 >= np) begin m_pair = 0; m_phase++; end
            else m_pair++;
        end
    endtask

    task automatic load(int kind, int taps, int seed);
        do_sel(kind, taps);
        for (int ph = 0; ph <= 32; ph++)
            for (int p = 0; p < (taps + 1) / 2; p++)
                do_dat(pat(seed, ph, 2*p), 1'b1, pat(seed, ph, 2*p + 1), 1'b1);
    endtask

    task automatic do_swap();
        int nb = 1 - mcur;
        bank_sel = nb[0];
        tick(); tick();
        chk({13'b0, live_bank}, 14'(mcur), "R7 live bank holds without frame_start");
        frame_start = 1'b1;
        tick();
        frame_start = 1'b0;
        mcur = nb;
        chk({13'b0, live_bank}, 14'(mcur), "R7 live bank follows bank_sel on frame_start");
    endtask

    task automatic rd(int kind, int ph, int tap, string tag);
        rd_kind = 3'(kind); rd_phase = 6'(ph); rd_tap = 3'(tap);
        tick();
        chk(rd_coef, exp_rd(kind, ph, tap), tag);
    endtask

    task automatic t_reset();
        chk({13'b0, live_bank}, 14'h0, "R1 live bank after reset");
        chk(rd_coef, 14'h0, "R1 rd_coef after reset");
    endtask

    task automatic t_basic();
        logic [13:0] prev;
        load(1, 8, 5);
        do_swap();
        rd(1, 0, 0, "R2 phase 0 tap 0");
        rd(1, 17, 6, "R2 phase 17 tap 6");
        rd(1, 32, 7, "R2 phase 32 tap 7");
        chk(rd_coef, pat(5, 32, 7) & 14'h3ffc, "R5 low bits cleared");
        prev = rd_coef;
        rd_kind = 3'd1; rd_phase = 6'd3; rd_tap = 3'd2;
        #1;
        chk(rd_coef, prev, "R11 output holds before edge");
        tick();
        chk(rd_coef, exp_rd(1, 3, 2), "R11 output after one edge");
        rd(1, 40, 2, "R8 mirror phase 40 tap 2");
        rd(1, 63, 0, "R8 mirror phase 63 tap 0");
        rd(1, 33, 7, "R8 mirror phase 33 tap 7");
    endtask

    task automatic t_odd();
        load(0, 5, 9);
        rd(0, 4, 1, "R7 pending bank not visible");
        do_dat(14'h3fff, 1'b1, 14'h3fff, 1'b1);
        do_swap();
        rd(0, 3, 5, "R4 odd half of last pair zero");
        rd(0, 3, 4, "R2 five taps last even tap");
        rd(0, 0, 0, "R6 phase 0 untouched after overrun write");
        rd(0, 0, 1, "R6 phase 0 odd untouched after overrun write");
        rd(0, 50, 6, "R9 mirrored tap beyond count");
        rd(0, 50, 1, "R8 mirror with five taps");
    endtask

    task automatic t_enables();
        do_sel(0, 5);
        do_dat(14'h1111, 1'b1, 14'h2222, 1'b1);
        do_sel(0, 5);
        do_dat(14'h3333, 1'b0, 14'h0447, 1'b1);
        do_swap();
        rd(0, 0, 0, "R3 disabled even half kept");
        chk(rd_coef, 14'h1110, "R3 even value");
        rd(0, 0, 1, "R3 enabled odd half written");
        chk(rd_coef, 14'h0444, "R5 odd value low bits cleared");
    endtask

    task automatic t_chroma();
        load(2, 4, 3);
        do_swap();
        chroma_sep = 1'b0;
        rd(2, 5, 1, "R10 chroma uses luma table");
        chk(rd_coef, pat(9, 5, 1) & 14'h3ffc, "R10 luma value");
        chroma_sep = 1'b1;
        rd(2, 5, 1, "R10 chroma uses own table");
        chk(rd_coef, pat(3, 5, 1) & 14'h3ffc, "R10 chroma value");
    endtask

    task automatic t_badkind();
        do_sel(6, 4);
        do_dat(14'h1234, 1'b1, 14'h2345, 1'b1);
        do_swap();
        rd(6, 0, 0, "R12 kind 6 reads zero");
        rd(7, 2, 3, "R12 kind 7 reads zero");
        rd(1, 40, 2, "R12 valid kind after invalid");
    endtask

    initial begin
        for (int b = 0; b < 2; b++)
            for (int k = 0; k < 8; k++) begin
                mtaps[b][k] = 0;
                for (int p = 0; p <= 32; p++)
                    for (int t = 0; t < 8; t++) mdl[b][k][p][t] = '0;
            end
        @(negedge clk);
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_basic();
        t_odd();
        t_enables();
        t_chroma();
        t_badkind();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule